// File: doc/BRIEF.md
# Bus Reset Sequencer with Configuration Strap Capture

This block drives the active-low reset line shared by the agents on a system bus. Reset is held while power-good is low and is then released only after a programmable hold time, counted in cycles of the reference clock. That count starts only once both power-good and the clock-valid flag are high. A warm-reset request reasserts the line at any time. Each new request restarts the hold, so a full interval always elapses after the latest request.

On the clock edge that releases reset, the block captures a vector of configuration straps from the bus. It holds that vector until the next release. When power-good drops, the reset line reasserts at once and the strap register clears, without waiting for a clock edge.

An agent-side model shows how a bus agent releases its outputs. Its output-enable follows the reset line through a short register delay, so the outputs drop within two clocks of seeing reset. One clock after release, a one-cycle start pulse tells the core to begin at its reset vector. The pulse is suppressed when the captured strap that selects tristated outputs is set. The straps and the control pins are level signals with no handshake. The straps must be stable at the releasing edge, and the block never stalls.

Top module: `bus_reset_seq`

## Requirements
- R1: While `pwr_ok` is low, `bus_rst_n`, `agent_oe`, `vec_start` and every bit of `strap_q` are 0, asynchronously and without a clock edge.
- R2: After power-on, `bus_rst_n` rises on exactly the HOLD_CYC-th rising edge at which `pwr_ok` and `clk_ok` are high and `warm_req` is low, counted from power-good rising. Reset is therefore low for at least HOLD_CYC cycles.
- R3: An edge at which `clk_ok` is low while reset is held restarts the count. The HOLD_CYC edges must then all follow that edge.
- R4: A rising edge that samples `warm_req` high leaves `bus_rst_n` low after that edge. Release then occurs on the HOLD_CYC-th following edge with `warm_req` low and `clk_ok` high.
- R5: A `warm_req` sampled while reset is already held, whether a new pulse or a held level, restarts the hold. Release is then measured from the last edge at which the request was high.
- R6: `strap_q` takes the value of `strap_in` sampled at the edge where `bus_rst_n` rises. It keeps that value, whatever `strap_in` does, until the next release.
- R7: `vec_start` is high for exactly one cycle, after the edge that follows the release edge, if `strap_q[TRI_BIT]` is 0. It stays low if that bit is 1 (1 = outputs held tristated).
- R8: `agent_oe` equals `bus_rst_n` delayed by OE_LAT rising edges (OE_LAT is 1 or 2). It is therefore low no later than the second edge after reset asserts, and rises OE_LAT edges after release.
- R9: Once reset is released, `clk_ok` has no effect on `bus_rst_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that counts the hold time |
| pwr_ok | input | 1 | Power-good; low forces reset asynchronously |
| clk_ok | input | 1 | Bus clock valid flag; gates the power-on count |
| warm_req | input | 1 | Warm-reset request, sampled each edge |
| strap_in | input | STRAP_W | Configuration straps from bus lines |
| bus_rst_n | output | 1 | Active-low bus reset to all agents |
| strap_q | output | STRAP_W | Straps captured at reset release |
| agent_oe | output | 1 | Modelled agent output-enable |
| vec_start | output | 1 | One-cycle start-at-reset-vector pulse |

## Verification
The bench builds the block with HOLD_CYC = 5, a 4-bit strap bus with bit 3 as the tristate select, and OE_LAT = 2. The short hold lets every release be counted edge by edge, including restarts from clock-valid dips, power-good dips and repeated or held warm requests. The 4-bit strap bus lets every strap value, 0 to 15, pass through a complete warm reset. Each pass checks the captured value, the start pulse with and without the tristate bit, and the output-enable fall and rise.

// File: rtl/bus_rst_pkg.sv
package bus_rst_pkg;
  // Hold-timer phase
  typedef enum logic {
    PH_HELD = 1'b0,
    PH_RUN  = 1'b1
  } rst_phase_e;
endpackage

// File: rtl/rst_hold_timer.sv
module rst_hold_timer #(
  parameter int HOLD_CYC = 100000
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic clk_ok,
  input  logic warm_req,
  output logic rst_n,
  output logic rel_now
);
  import bus_rst_pkg::*;

  localparam int CW = (HOLD_CYC < 2) ? 1 : $clog2(HOLD_CYC);
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYC - 1);

  rst_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          at_last;

  assign at_last = (cnt == LAST);
  assign rel_now = (phase == PH_HELD) && !warm_req && clk_ok && at_last;
  assign rst_n   = (phase == PH_RUN);

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      phase <= PH_HELD;
      cnt   <= '0;
    end else if (warm_req) begin
      phase <= PH_HELD;
      cnt   <= '0;
    end else if (phase == PH_HELD) begin
      if (!clk_ok) begin
        cnt <= '0;
      end else if (at_last) begin
        phase <= PH_RUN;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
  parameter int STRAP_W = 8
) (
  input  logic               clk,
  input  logic               pwr_ok,
  input  logic               cap_en,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q
);
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)     strap_q <= '0;
    else if (cap_en) strap_q <= strap_in;
  end
endmodule

// File: rtl/agent_oe_model.sv
module agent_oe_model #(
  parameter int OE_LAT = 2
) (
  input  logic clk,
  input  logic pwr_ok,
  input  logic rst_seen_n,
  output logic oe
);
  generate
    if (OE_LAT <= 1) begin : g_one
      always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) oe <= 1'b0;
        else         oe <= rst_seen_n;
      end
    end else begin : g_two
      logic stage1;
      always_ff @(posedge clk or negedge pwr_ok) begin
        if (!pwr_ok) begin
          stage1 <= 1'b0;
          oe     <= 1'b0;
        end else begin
          stage1 <= rst_seen_n;
          oe     <= stage1;
        end
      end
    end
  endgenerate
endmodule

// File: rtl/bus_reset_seq.sv
module bus_reset_seq #(
  parameter int HOLD_CYC = 100000,
  parameter int STRAP_W  = 8,
  parameter int TRI_BIT  = 7,
  parameter int OE_LAT   = 2
) (
  input  logic               clk,
  input  logic               pwr_ok,
  input  logic               clk_ok,
  input  logic               warm_req,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               bus_rst_n,
  output logic [STRAP_W-1:0] strap_q,
  output logic               agent_oe,
  output logic               vec_start
);
  logic rel_now;
  logic rel_d;

  rst_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .clk_ok   (clk_ok),
    .warm_req (warm_req),
    .rst_n    (bus_rst_n),
    .rel_now  (rel_now)
  );

  strap_capture #(.STRAP_W(STRAP_W)) u_strap (
    .clk      (clk),
    .pwr_ok   (pwr_ok),
    .cap_en   (rel_now),
    .strap_in (strap_in),
    .strap_q  (strap_q)
  );

  agent_oe_model #(.OE_LAT(OE_LAT)) u_agent (
    .clk        (clk),
    .pwr_ok     (pwr_ok),
    .rst_seen_n (bus_rst_n),
    .oe         (agent_oe)
  );

  // Start pulse one clock after release, unless tristate strap set
  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok) begin
      rel_d     <= 1'b0;
      vec_start <= 1'b0;
    end else begin
      rel_d     <= rel_now;
      vec_start <= rel_d && !strap_q[TRI_BIT];
    end
  end
endmodule

// File: rtl/bus_reset_seq_chk.sv
module bus_reset_seq_chk #(
  parameter int HOLD_CYC = 100000,
  parameter int STRAP_W  = 8,
  parameter int TRI_BIT  = 7
) (
  input logic               clk,
  input logic               pwr_ok,
  input logic               warm_req,
  input logic               bus_rst_n,
  input logic [STRAP_W-1:0] strap_q,
  input logic               agent_oe,
  input logic               vec_start
);
  localparam int LW = $clog2(HOLD_CYC + 2);
  localparam logic [LW-1:0] SAT = LW'(HOLD_CYC);

  logic [LW-1:0] low_run;

  always_ff @(posedge clk or negedge pwr_ok) begin
    if (!pwr_ok)          low_run <= '0;
    else if (bus_rst_n)   low_run <= '0;
    else if (low_run < SAT) low_run <= low_run + 1'b1;
  end

  always @(negedge clk) begin
    if (!pwr_ok)
      AST_PG_CLEARS: assert (!bus_rst_n && !agent_oe && !vec_start && strap_q == '0); // R1
  end

  AST_HOLD_MIN: assert property (@(posedge clk) disable iff (!pwr_ok)
    $rose(bus_rst_n) |-> (low_run >= SAT)); // R2

  AST_WARM_ASSERTS: assert property (@(posedge clk) disable iff (!pwr_ok)
    warm_req |=> !bus_rst_n); // R4

  AST_STRAP_HELD: assert property (@(posedge clk) disable iff (!pwr_ok)
    !$rose(bus_rst_n) |-> $stable(strap_q)); // R6

  AST_VEC_ONE_SHOT: assert property (@(posedge clk) disable iff (!pwr_ok)
    vec_start |=> !vec_start); // R7

  AST_VEC_AFTER_REL: assert property (@(posedge clk) disable iff (!pwr_ok)
    vec_start |-> ($past(bus_rst_n) && !$past(bus_rst_n, 2) && !strap_q[TRI_BIT])); // R7

  AST_OE_DEADLINE: assert property (@(posedge clk) disable iff (!pwr_ok)
    $past(!bus_rst_n, 2) |-> !agent_oe); // R8
endmodule

bind bus_reset_seq bus_reset_seq_chk #(
  .HOLD_CYC (HOLD_CYC),
  .STRAP_W  (STRAP_W),
  .TRI_BIT  (TRI_BIT)
) u_chk (
  .clk       (clk),
  .pwr_ok    (pwr_ok),
  .warm_req  (warm_req),
  .bus_rst_n (bus_rst_n),
  .strap_q   (strap_q),
  .agent_oe  (agent_oe),
  .vec_start (vec_start)
);

// File: tb/bus_reset_seq_tb.sv
module bus_reset_seq_tb;
  localparam int H   = 5;
  localparam int SW  = 4;
  localparam int TB  = 3;
  localparam int PER = 4;

  logic          clk = 1'b0;
  logic          pwr_ok = 1'b0;
  logic          clk_ok = 1'b0;
  logic          warm_req = 1'b0;
  logic [SW-1:0] strap_in = '0;
  logic          bus_rst_n;
  logic [SW-1:0] strap_q;
  logic          agent_oe;
  logic          vec_start;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(PER/2) clk = ~clk;

  bus_reset_seq #(.HOLD_CYC(H), .STRAP_W(SW), .TRI_BIT(TB), .OE_LAT(2)) u_dut (
    .clk(clk), .pwr_ok(pwr_ok), .clk_ok(clk_ok), .warm_req(warm_req),
    .strap_in(strap_in), .bus_rst_n(bus_rst_n), .strap_q(strap_q),
    .agent_oe(agent_oe), .vec_start(vec_start)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    chk(act == exp, req, act, exp);
  endtask

  // Counts edges until release; checks reset stays low meanwhile
  task automatic count_release(output int n);
    n = 0;
    while (!bus_rst_n && n < 40) begin
      tick();
      n++;
    end
  endtask

  task automatic chk_zero_state(input string req);
    chk_eq(req, {29'd0, bus_rst_n, agent_oe, vec_start}, 0);
    chk_eq(req, int'(strap_q), 0);
  endtask

  initial begin
    int n;
    // R1: reset state with power-good low
    repeat (3) tick();
    chk_zero_state("R1");

    // R2: power-on with clock-valid arriving after d edges
    for (int d = 0; d < 4; d++) begin
      pwr_ok = 1'b0; clk_ok = 1'b0;
      #1;
      chk_zero_state("R1");
      tick();
      pwr_ok = 1'b1;
      for (int k = 0; k < d; k++) begin
        tick();
        chk_eq("R2", int'(bus_rst_n), 0);
      end
      clk_ok = 1'b1;
      count_release(n);
      chk_eq("R2", n, H);
    end

    // R3: clock-valid dip during hold restarts count
    pwr_ok = 1'b0; #1; tick();
    pwr_ok = 1'b1;
    tick(); tick();
    clk_ok = 1'b0; tick();
    clk_ok = 1'b1;
    count_release(n);
    chk_eq("R3", n, H);

    // R1: power-good dip during hold restarts count
    pwr_ok = 1'b0; #1; tick();
    pwr_ok = 1'b1;
    repeat (3) tick();
    pwr_ok = 1'b0; #1;
    chk_zero_state("R1");
    tick();
    pwr_ok = 1'b1;
    count_release(n);
    chk_eq("R1", n, H);

    // R1: asynchronous clear after release
    strap_in = 4'hA;
    warm_req = 1'b1; tick(); warm_req = 1'b0;
    count_release(n);
    repeat (3) tick();
    chk_eq("R6", int'(strap_q), 'hA);
    pwr_ok = 1'b0; #1;
    chk_zero_state("R1");
    tick();
    pwr_ok = 1'b1;
    count_release(n);
    repeat (3) tick();

    // R9: clock-valid loss after release has no effect
    clk_ok = 1'b0;
    for (int k = 0; k < 3; k++) begin
      tick();
      chk_eq("R9", int'(bus_rst_n), 1);
    end
    clk_ok = 1'b1;

    // R5: second request pulse during hold
    warm_req = 1'b1; tick(); warm_req = 1'b0;
    tick(); tick();
    warm_req = 1'b1; tick(); warm_req = 1'b0;
    count_release(n);
    chk_eq("R5", n, H);
    repeat (3) tick();

    // R5: held request level
    warm_req = 1'b1;
    repeat (4) tick();
    chk_eq("R5", int'(bus_rst_n), 0);
    warm_req = 1'b0;
    count_release(n);
    chk_eq("R5", n, H);
    repeat (3) tick();

    // R4 R6 R7 R8: warm reset for every strap value
    for (int s = 0; s < (1 << SW); s++) begin
      strap_in = SW'(s);
      warm_req = 1'b1;
      tick();
      warm_req = 1'b0;
      chk_eq("R4", int'(bus_rst_n), 0);
      chk_eq("R8", int'(agent_oe), 1);
      n = 0;
      while (!bus_rst_n && n < 40) begin
        tick();
        n++;
        if (!bus_rst_n) chk_eq("R8", int'(agent_oe), (n < 2) ? 1 : 0);
      end
      chk_eq("R4", n, H);
      chk_eq("R6", int'(strap_q), s);
      chk_eq("R7", int'(vec_start), 0);
      chk_eq("R8", int'(agent_oe), 0);
      strap_in = ~SW'(s);
      tick();
      chk_eq("R7", int'(vec_start), ((s >> TB) & 1) ? 0 : 1);
      chk_eq("R8", int'(agent_oe), 0);
      tick();
      chk_eq("R7", int'(vec_start), 0);
      chk_eq("R6", int'(strap_q), s);
      chk_eq("R8", int'(agent_oe), 1);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PER * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule